// File: doc/BRIEF.md
# Coupled Two-Branch Decision Feedback Slicer with Precomputed Candidates

This block closes the decision loop of a two-output decision feedback equalizer. It takes one in-phase and one quadrature soft value per symbol from an upstream feedforward filter. It returns one binary decision per branch per symbol.

The feedback correction for each branch depends on the last `MB` decisions of both branches. The block does no arithmetic inside the recursion. It keeps a table with every feedback value the decision history could call for, 2^(2·MB) entries per branch. As a symbol arrives, each entry is added to the soft value and sliced. Only then does the stored history pick one of the sliced bits. The recursive path is therefore one register and a 1-bit multiplexer.

The feedback coefficients are loaded through a simple write port. The candidate table is rebuilt after each write.

Top module: `precomp_dfe_loop`

## Requirements
- R1: While reset is held, and after it is released until the first decision, `decValid`, `decI` and `decQ` are 0. The decision history starts at all zeros, so the first symbol uses a feedback value of zero.
- R2: A write with `coefWrEn` high stores `coefData` at index `coefAddr = out*2*MB + src*MB + (tap-1)`. Here `out` is the output being corrected (0 = in-phase, 1 = quadrature), `src` is the branch whose past decision gates the coefficient (0 = in-phase, 1 = quadrature), and `tap` runs 1..MB for the decision made `tap` symbols earlier. A new coefficient applies to every symbol sampled two or more clock edges after the edge that captured the write.
- R3: A decision is 1 when the saturated 8-bit sum of the soft input and the selected feedback value is greater than or equal to zero. Otherwise it is 0.
- R4: The feedback value of an output is the sum of the coefficients whose gating past decision is 1, clamped to the signed range [-128, 127] before it is added to the soft input.
- R5: Each output's feedback uses past decisions of both branches. A coefficient with `src` different from `out` couples the two branches.
- R6: A symbol sampled with `symValid` high at one rising edge yields its decisions, with `decValid` high, at the second rising edge after that one.
- R7: The decision history advances only on accepted symbols. Idle cycles between symbols leave it unchanged.
- R8: `decValid` is high for exactly one cycle per accepted symbol. `decI` and `decQ` hold their values while `decValid` is low.
- R9: Symbols may be accepted on every clock cycle with no gap. Each decision then feeds the very next symbol's selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| symValid | input | 1 | Soft values present this cycle |
| ffI | input | DATA_W | Signed in-phase soft value from the feedforward filter |
| ffQ | input | DATA_W | Signed quadrature soft value from the feedforward filter |
| coefWrEn | input | 1 | Feedback coefficient write strobe |
| coefAddr | input | log2(4·MB) | Coefficient index as in R2 |
| coefData | input | DATA_W | Signed coefficient value |
| decValid | output | 1 | Decisions valid this cycle |
| decI | output | 1 | In-phase decision |
| decQ | output | 1 | Quadrature decision |

## Verification
A wrong history bit, a wrong table entry or a wrong coefficient index is not visible in one symbol. It selects the wrong sliced candidate only when the soft value lies between the correct and the wrong feedback sums. The error then feeds back and can change the following decisions. The bench therefore compares every cycle against a direct-form model that sums the feedback explicitly. It uses coefficient sets that make single bits decisive: large saturating taps, pure cross-branch taps, and random sets rewritten during the run. With these, a fault shows within a few symbols of the first affected decision. Idle gaps check that the history freezes without disturbing the held outputs.

// File: rtl/dfe_loop_pkg.sv
package dfe_loop_pkg;
  // Strobes from control to datapath, both one cycle after their trigger.
  typedef struct packed {
    logic rebuild;  // recompute candidate feedback table
    logic advance;  // select decision, shift history
  } loop_strobe_t;
endpackage

// File: rtl/dfe_loop_ctrl.sv
module dfe_loop_ctrl
  import dfe_loop_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         symValid,
  input  logic         coefWrEn,
  output loop_strobe_t stb
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stb <= '0;
    end else begin
      stb.rebuild <= coefWrEn;
      stb.advance <= symValid;
    end
  end
endmodule

// File: rtl/dfe_loop_datapath.sv
module dfe_loop_datapath
  import dfe_loop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MB     = 2,
  localparam int NHIST   = 2 * MB,
  localparam int NCAND   = 1 << NHIST,
  localparam int NCOEF   = 2 * NHIST,
  localparam int COEF_AW = $clog2(NCOEF),
  localparam int ACC_W   = DATA_W + NHIST + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  loop_strobe_t             stb,
  input  logic                     symValid,
  input  logic signed [DATA_W-1:0] ffI,
  input  logic signed [DATA_W-1:0] ffQ,
  input  logic                     coefWrEn,
  input  logic [COEF_AW-1:0]       coefAddr,
  input  logic signed [DATA_W-1:0] coefData,
  output logic                     decValid,
  output logic                     decI,
  output logic                     decQ
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] ACC_MIN = ~ACC_MAX;

  function automatic logic signed [ACC_W-1:0] sext(input logic signed [DATA_W-1:0] v);
    return {{(ACC_W - DATA_W){v[DATA_W-1]}}, v};
  endfunction

  function automatic logic signed [DATA_W-1:0] satAcc(input logic signed [ACC_W-1:0] x);
    logic signed [ACC_W-1:0] c;
    if (x > ACC_MAX)      c = ACC_MAX;
    else if (x < ACC_MIN) c = ACC_MIN;
    else                  c = x;
    return c[DATA_W-1:0];
  endfunction

  // Coefficient store: index = out*NHIST + src*MB + (tap-1)
  logic signed [DATA_W-1:0] coefMem [NCOEF];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NCOEF; i++) coefMem[i] <= '0;
    end else if (coefWrEn && (int'(coefAddr) < NCOEF)) begin
      coefMem[coefAddr] <= coefData;
    end
  end

  logic [NCAND-1:0] candI, candQ, candIReg, candQReg;

  // One candidate per history pattern; history bit b = src*MB + (tap-1)
  for (genvar k = 0; k < NCAND; k++) begin : g_cand
    logic signed [ACC_W-1:0]  fbI, fbQ, uI, uQ;
    logic signed [DATA_W-1:0] tabI, tabQ, sumI, sumQ;

    always_comb begin
      fbI = '0;
      fbQ = '0;
      for (int b = 0; b < NHIST; b++) begin
        if (((k >> b) & 1) != 0) begin
          fbI = fbI + sext(coefMem[b]);
          fbQ = fbQ + sext(coefMem[NHIST + b]);
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tabI <= '0;
        tabQ <= '0;
      end else if (stb.rebuild) begin
        tabI <= satAcc(fbI);
        tabQ <= satAcc(fbQ);
      end
    end

    always_comb begin
      uI   = sext(ffI) + sext(tabI);
      uQ   = sext(ffQ) + sext(tabQ);
      sumI = satAcc(uI);
      sumQ = satAcc(uQ);
      candI[k] = ~sumI[DATA_W-1];
      candQ[k] = ~sumQ[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candIReg <= '0;
      candQReg <= '0;
    end else if (symValid) begin
      candIReg <= candI;
      candQReg <= candQ;
    end
  end

  // Recursive loop: history register -> 1-bit mux -> history register
  logic [NHIST-1:0] histReg, histNext;
  logic             newI, newQ;

  assign newI = candIReg[histReg];
  assign newQ = candQReg[histReg];

  always_comb begin
    histNext = histReg;
    histNext[0]  = newI;
    histNext[MB] = newQ;
    for (int m = 1; m < MB; m++) begin
      histNext[m]      = histReg[m - 1];
      histNext[MB + m] = histReg[MB + m - 1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histReg  <= '0;
      decI     <= 1'b0;
      decQ     <= 1'b0;
      decValid <= 1'b0;
    end else begin
      decValid <= stb.advance;
      if (stb.advance) begin
        histReg <= histNext;
        decI    <= newI;
        decQ    <= newQ;
      end
    end
  end
endmodule

// File: rtl/precomp_dfe_loop.sv
module precomp_dfe_loop
  import dfe_loop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MB     = 2,
  localparam int COEF_AW = $clog2(4 * MB)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     symValid,
  input  logic signed [DATA_W-1:0] ffI,
  input  logic signed [DATA_W-1:0] ffQ,
  input  logic                     coefWrEn,
  input  logic [COEF_AW-1:0]       coefAddr,
  input  logic signed [DATA_W-1:0] coefData,
  output logic                     decValid,
  output logic                     decI,
  output logic                     decQ
);
  loop_strobe_t stb;

  dfe_loop_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .symValid (symValid),
    .coefWrEn (coefWrEn),
    .stb      (stb)
  );

  dfe_loop_datapath #(.DATA_W(DATA_W), .MB(MB)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .symValid (symValid),
    .ffI      (ffI),
    .ffQ      (ffQ),
    .coefWrEn (coefWrEn),
    .coefAddr (coefAddr),
    .coefData (coefData),
    .decValid (decValid),
    .decI     (decI),
    .decQ     (decQ)
  );
endmodule

// File: rtl/dfe_loop_chk.sv
module dfe_loop_chk (
  input logic clk,
  input logic rstN,
  input logic symValid,
  input logic decValid,
  input logic decI,
  input logic decQ
);
  // R1: outputs cleared while reset is held
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |-> (!decValid && !decI && !decQ));

  // R6: accepted symbol produces a valid decision two edges later
  a_r6_latency: assert property (@(posedge clk) disable iff (!rstN)
    $past(symValid, 2) |-> decValid);

  // R8: no valid without an accepted symbol two edges earlier
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(symValid, 2));

  // R8: decisions hold while not valid
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> $stable({decI, decQ}));
endmodule

bind precomp_dfe_loop dfe_loop_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .symValid (symValid),
  .decValid (decValid),
  .decI     (decI),
  .decQ     (decQ)
);

// File: tb/precomp_dfe_loop_bench.sv
module precomp_dfe_loop_bench;
  localparam int DATA_W = 8;
  localparam int MB     = 2;
  localparam int NCOEF  = 4 * MB;
  localparam int AW     = $clog2(NCOEF);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic symValid = 1'b0;
  logic signed [DATA_W-1:0] ffI = '0, ffQ = '0;
  logic coefWrEn = 1'b0;
  logic [AW-1:0] coefAddr = '0;
  logic signed [DATA_W-1:0] coefData = '0;
  logic decValid, decI, decQ;

  always #10 clk = ~clk;  // 50 MHz

  precomp_dfe_loop #(.DATA_W(DATA_W), .MB(MB)) u_precomp_dfe_loop (
    .clk(clk), .rstN(rstN), .symValid(symValid), .ffI(ffI), .ffQ(ffQ),
    .coefWrEn(coefWrEn), .coefAddr(coefAddr), .coefData(coefData),
    .decValid(decValid), .decI(decI), .decQ(decQ)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;
  string curReq = "R1";

  // reference model state
  int mc [NCOEF];
  int hI [MB];
  int hQ [MB];
  bit expV [2];
  bit expI [2];
  bit expQ [2];
  bit lastI = 0, lastQ = 0;

  function automatic int sat8(int x);
    if (x > 127) return 127;
    if (x < -128) return -128;
    return x;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // direct-form model of one symbol
  task automatic modelSym(int yi, int yq, output bit di, output bit dq);
    int fbI, fbQ;
    fbI = 0; fbQ = 0;
    for (int m = 0; m < MB; m++) begin
      if (hI[m] != 0) begin fbI += mc[m];      fbQ += mc[2*MB + m];      end
      if (hQ[m] != 0) begin fbI += mc[MB + m]; fbQ += mc[2*MB + MB + m]; end
    end
    di = sat8(yi + sat8(fbI)) >= 0;
    dq = sat8(yq + sat8(fbQ)) >= 0;
    for (int m = MB - 1; m > 0; m--) begin hI[m] = hI[m-1]; hQ[m] = hQ[m-1]; end
    hI[0] = di; hQ[0] = dq;
  endtask

  // one clock: compare outputs of the previous edge, then drive next inputs
  task automatic step(bit v, int yi, int yq, bit wr, int addr, int data);
    bit di, dq;
    @(negedge clk);
    if (expV[1]) begin
      check(curReq, "decValid", decValid, 1);
      check(curReq, "decI", decI, expI[1]);
      check(curReq, "decQ", decQ, expQ[1]);
      lastI = expI[1]; lastQ = expQ[1];
    end else begin
      check("R8", "decValid idle", decValid, 0);
      check("R8", "decI hold", decI, lastI);
      check("R8", "decQ hold", decQ, lastQ);
    end
    expV[1] = expV[0]; expI[1] = expI[0]; expQ[1] = expQ[0];
    di = 0; dq = 0;
    if (v) modelSym(yi, yq, di, dq);
    expV[0] = v; expI[0] = di; expQ[0] = dq;
    if (wr) mc[addr] = data;
    symValid = v;
    ffI = DATA_W'(yi);
    ffQ = DATA_W'(yq);
    coefWrEn = wr;
    coefAddr = AW'(addr);
    coefData = DATA_W'(data);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  // R2: coefficient index = out*2*MB + src*MB + (tap-1)
  task automatic writeCoef(int outB, int src, int tap, int val);
    step(0, 0, 0, 1, outB*2*MB + src*MB + tap - 1, val);
  endtask

  task automatic loadAll(int vals [NCOEF]);
    for (int a = 0; a < NCOEF; a++) step(0, 0, 0, 1, a, vals[a]);
    idle(2);
  endtask

  function automatic int rnd8();
    return int'($urandom_range(255)) - 128;
  endfunction

  initial begin
    for (int i = 0; i < NCOEF; i++) mc[i] = 0;
    for (int m = 0; m < MB; m++) begin hI[m] = 0; hQ[m] = 0; end
    expV = '{0, 0}; expI = '{0, 0}; expQ = '{0, 0};
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "decValid in reset", decValid, 0);
    check("R1", "decI in reset", decI, 0);
    check("R1", "decQ in reset", decQ, 0);
    rstN = 1'b1;
    idle(2);

    // R1/R3: first symbol after reset, zero history, with nonzero taps loaded
    curReq = "R1";
    writeCoef(0, 0, 1, -100);
    writeCoef(1, 1, 1, -100);
    idle(2);
    step(1, 0, -1, 0, 0, 0);
    idle(3);

    // R3: zero feedback gives the sign of the soft value, boundary at 0 and -1
    curReq = "R3";
    begin
      int z [NCOEF];
      for (int i = 0; i < NCOEF; i++) z[i] = 0;
      loadAll(z);
    end
    step(1, 0, -1, 0, 0, 0);
    step(1, -1, 0, 0, 0, 0);
    step(1, 127, -128, 0, 0, 0);
    idle(3);

    // R4: two taps of 127 clamp to 127, so -128 + 127 = -1 gives 0
    curReq = "R4";
    writeCoef(0, 0, 1, 127);
    writeCoef(0, 1, 1, 127);
    idle(2);
    step(1, 100, 100, 0, 0, 0);
    step(1, -128, 0, 0, 0, 0);
    step(1, -128, 0, 0, 0, 0);
    idle(3);

    // R5: only cross-branch taps
    curReq = "R5";
    begin
      int z [NCOEF];
      for (int i = 0; i < NCOEF; i++) z[i] = 0;
      z[MB] = -90; z[MB+1] = 40; z[2*MB] = 70; z[2*MB+1] = -60;
      loadAll(z);
    end
    for (int i = 0; i < 40; i++) step(1, rnd8() / 2, rnd8() / 2, 0, 0, 0);
    idle(3);

    // R9/R6: back-to-back random symbols, random coefficients
    curReq = "R9";
    for (int round = 0; round < 4; round++) begin
      int z [NCOEF];
      for (int i = 0; i < NCOEF; i++) z[i] = rnd8();
      loadAll(z);
      for (int i = 0; i < 60; i++) step(1, rnd8(), rnd8(), 0, 0, 0);
    end
    idle(3);

    // R7: random idle gaps between symbols
    curReq = "R7";
    for (int i = 0; i < 200; i++) begin
      step(1, rnd8(), rnd8(), 0, 0, 0);
      if ($urandom_range(2) == 0) idle(int'($urandom_range(3)) + 1);
    end
    idle(3);

    // R2: single-coefficient rewrites during the run
    curReq = "R2";
    for (int i = 0; i < 30; i++) begin
      writeCoef(int'($urandom_range(1)), int'($urandom_range(1)),
                int'($urandom_range(MB - 1)) + 1, rnd8());
      idle(1);
      for (int j = 0; j < 8; j++) step(1, rnd8() / 2, rnd8() / 2, 0, 0, 0);
    end
    idle(4);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule